// File: doc/BRIEF.md
# SPI NOR Program and Erase Sequencer

This block turns single program or erase requests from a host into the full command sequence that a serial NOR flash needs. It drives the flash over one-lane SPI in mode 0. Every request is bracketed the same way. The block sets the write-enable latch and confirms it through the status register. It then sends the program or erase frame and waits for the busy flag to clear. Finally it clears the latch again and confirms the device is idle. After that it pulses `op_done`. A request the block refuses produces a one-cycle `op_err` and no bus activity.

A program request names a 24-bit start address and a byte count. The bytes are then pulled one by one over a valid/ready stream while chip select stays low. The flash accepts at most one page per program frame. When the running address reaches a page boundary, the block closes the frame and waits out the busy period. It then sets the write-enable latch again and reopens a program frame at the new address. The host sees one uninterrupted stream. Status polling has no timeout. Between frames, chip select is held high for at least a run-time programmable number of clock cycles.

Top module: `nor_pe_seq`

## Requirements
- R1: While and right after reset, `spi_cs_n` is 1, `spi_sclk` is 0 and `op_done`/`op_err` are 0. `req_ready` rises once the chip-select guard time has passed.
- R2: An erase request whose address has any of bits 11..0 set is refused. `op_err` pulses for one cycle, no chip-select frame is opened and `op_done` stays low.
- R3: A program request (`req_erase`=0) with `req_len`=0 is refused the same way as R2.
- R4: A program frame is opcode 0x02 and an erase frame is opcode 0x20. Each opcode is followed by three address bytes, most significant first, and then, for program, the data bytes in stream order. Every bit is sent MSB first.
- R5: Each accepted request begins with a write-enable frame (opcode 0x06). Before each program or erase frame, status is read with opcode 0x05 until its bits 1..0 equal 2'b10 (bit 1 is the write-enable latch, bit 0 is busy).
- R6: After a program or erase frame, no frame other than status reads is issued until a status byte shows bit 0 clear.
- R7: No program frame carries more than 256 data bytes or crosses a 256-byte page. A request touching N pages produces exactly N program frames.
- R8: Each accepted request ends with a write-disable frame (opcode 0x04), then status reads until bit 0 is clear, then `op_done`. The write-enable latch is clear at the end.
- R9: An aligned erase request sets all 4096 bytes of its sector to 0xFF and leaves the rest of the flash unchanged.
- R10: SCLK idles low, and `spi_sclk` is low whenever `spi_cs_n` changes (SPI mode 0).
- R11: Between any two frames, `spi_cs_n` stays high for at least `gap_cycles` clock cycles.
- R12: `op_done` is a single-cycle pulse per accepted request, and `req_ready` is low from acceptance until that pulse.
- R13: Data is taken only when `wr_ready` and `wr_valid` are both high. Host stalls on `wr_valid` do not change the programmed contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host presents a request |
| req_ready | output | 1 | Block idle and guard time met; request taken when both are high |
| req_erase | input | 1 | 1 = sector erase, 0 = program |
| req_addr | input | 24 | Flash start address (erase: sector base) |
| req_len | input | LEN_W | Program byte count |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte valid |
| wr_ready | output | 1 | Block accepts a data byte this cycle |
| gap_cycles | input | GAP_W | Minimum chip-select high time in clock cycles |
| op_done | output | 1 | Pulse: request completed |
| op_err | output | 1 | Pulse: request refused |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench attaches a behavioural flash that decodes frames and models the latch, a multi-read busy period and AND-only programming. Page programming in the model wraps inside the page, so a design that failed to split at a boundary would overwrite the start of the page. That shows up as wrong memory contents and too few program frames. The sweep targets starts one byte before a boundary, exact full pages, a single byte, a run spanning three pages and stalled data. A missing busy or latch poll would appear as a frame sent while the model is busy or not write-enabled. A misaligned erase or a zero count that is not refused would show up as an opened frame or a `op_done`. The guard time is swept from 0 to 3 cycles to catch an off-by-one in the chip-select high time.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam int ADDR_W = 24;

  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_ERASE = 8'h20;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WREN,
    ST_RDSR,
    ST_POLL,
    ST_CMD,
    ST_ADDR,
    ST_DWAIT,
    ST_DATA,
    ST_WRDI,
    ST_GAP
  } seq_state_e;
endpackage

// File: rtl/nor_spi_byte.sv
// One byte, mode 0: MOSI set while SCLK low, MISO sampled on the rising edge.
module nor_spi_byte #(
  parameter int SCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx,
  output logic       active
);
  localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  logic [CW-1:0] hcnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          tick;

  assign tick = (hcnt == CW'(SCLK_HALF - 1));

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      hcnt   <= '0;
      bitn   <= '0;
      sh     <= '0;
      rx     <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        sh     <= tx;
        mosi   <= tx[7];
        hcnt   <= '0;
        bitn   <= '0;
      end
    end else if (tick) begin
      hcnt <= '0;
      if (!sclk) begin
        sclk <= 1'b1;
        rx   <= {rx[6:0], miso};
      end else begin
        sclk <= 1'b0;
        if (bitn == 3'd7) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          bitn <= bitn + 3'd1;
          sh   <= {sh[6:0], 1'b0};
          mosi <= sh[6];
        end
      end
    end else begin
      hcnt <= hcnt + CW'(1);
    end
  end

  a_r10_sclk_rests_low: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sclk);
endmodule

// File: rtl/nor_cs_guard.sv
// Counts cycles of chip select high (saturating) and reports when the minimum is met.
module nor_cs_guard #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic [GAP_W-1:0] min_cyc,
  output logic             gap_ok
);
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !cs_n) cnt <= '0;
    else if (cnt != '1) cnt <= cnt + GAP_W'(1);
  end

  assign gap_ok = (cnt >= min_cyc);

  a_r11_gap_before_fall: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(cs_n)) |-> ($past(cnt) >= $past(min_cyc)));
endmodule

// File: rtl/nor_pe_seq.sv
module nor_pe_seq
  import nor_seq_pkg::*;
#(
  parameter int LEN_W        = 16,
  parameter int GAP_W        = 8,
  parameter int SCLK_HALF    = 2,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [GAP_W-1:0]  gap_cycles,
  output logic              op_done,
  output logic              op_err,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int SEC_W = $clog2(SECTOR_BYTES);

  seq_state_e        state, ret_state, poll_next;
  logic              poll_wel, is_erase;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  remain;
  logic [1:0]        aidx;
  logic              eng_start, eng_done, eng_active;
  logic [7:0]        eng_tx, eng_rx;
  logic              gap_ok;
  logic              poll_hit;

  nor_spi_byte #(.SCLK_HALF(SCLK_HALF)) u_byte (
    .clk(clk), .rst(rst), .start(eng_start), .tx(eng_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(eng_done), .rx(eng_rx),
    .active(eng_active)
  );

  nor_cs_guard #(.GAP_W(GAP_W)) u_guard (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .min_cyc(gap_cycles), .gap_ok(gap_ok)
  );

  assign req_ready = (state == ST_IDLE) && gap_ok;
  assign wr_ready  = (state == ST_DWAIT);
  assign poll_hit  = poll_wel ? ((eng_rx & 8'h03) == 8'h02)
                              : ((eng_rx & 8'h01) == 8'h00);

  always_ff @(posedge clk) begin
    eng_start <= 1'b0;
    op_done   <= 1'b0;
    op_err    <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      ret_state <= ST_IDLE;
      poll_next <= ST_IDLE;
      poll_wel  <= 1'b0;
      is_erase  <= 1'b0;
      addr      <= '0;
      remain    <= '0;
      aidx      <= '0;
      eng_tx    <= '0;
      spi_cs_n  <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (req_valid && gap_ok) begin
          if (req_erase ? (req_addr[SEC_W-1:0] != '0) : (req_len == '0)) begin
            op_err <= 1'b1;
          end else begin
            is_erase  <= req_erase;
            addr      <= req_addr;
            remain    <= req_len;
            spi_cs_n  <= 1'b0;
            eng_start <= 1'b1;
            eng_tx    <= OPC_WREN;
            state     <= ST_WREN;
          end
        end
        ST_WREN: if (eng_done) begin
          spi_cs_n  <= 1'b1;
          state     <= ST_GAP;
          ret_state <= ST_RDSR;
          poll_wel  <= 1'b1;
          poll_next <= ST_CMD;
        end
        ST_RDSR: if (eng_done) begin
          eng_start <= 1'b1;
          eng_tx    <= 8'h00;
          state     <= ST_POLL;
        end
        ST_POLL: if (eng_done) begin
          if (poll_hit) begin
            spi_cs_n <= 1'b1;
            if (poll_next == ST_IDLE) begin
              op_done <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              state     <= ST_GAP;
              ret_state <= poll_next;
            end
          end else begin
            eng_start <= 1'b1;
            eng_tx    <= 8'h00;
          end
        end
        ST_CMD: if (eng_done) begin
          eng_start <= 1'b1;
          eng_tx    <= addr[23:16];
          aidx      <= 2'd0;
          state     <= ST_ADDR;
        end
        ST_ADDR: if (eng_done) begin
          case (aidx)
            2'd0: begin
              eng_start <= 1'b1;
              eng_tx    <= addr[15:8];
              aidx      <= 2'd1;
            end
            2'd1: begin
              eng_start <= 1'b1;
              eng_tx    <= addr[7:0];
              aidx      <= 2'd2;
            end
            default: begin
              if (is_erase) begin
                spi_cs_n  <= 1'b1;
                state     <= ST_GAP;
                ret_state <= ST_RDSR;
                poll_wel  <= 1'b0;
                poll_next <= ST_WRDI;
              end else begin
                state <= ST_DWAIT;
              end
            end
          endcase
        end
        ST_DWAIT: if (wr_valid) begin
          eng_start <= 1'b1;
          eng_tx    <= wr_data;
          state     <= ST_DATA;
        end
        ST_DATA: if (eng_done) begin
          addr   <= addr + ADDR_W'(1);
          remain <= remain - LEN_W'(1);
          if (remain == LEN_W'(1) || addr[PG_W-1:0] == '1) begin
            spi_cs_n  <= 1'b1;
            state     <= ST_GAP;
            ret_state <= ST_RDSR;
            poll_wel  <= 1'b0;
            poll_next <= (remain == LEN_W'(1)) ? ST_WRDI : ST_WREN;
          end else begin
            state <= ST_DWAIT;
          end
        end
        ST_WRDI: if (eng_done) begin
          spi_cs_n  <= 1'b1;
          state     <= ST_GAP;
          ret_state <= ST_RDSR;
          poll_wel  <= 1'b0;
          poll_next <= ST_IDLE;
        end
        ST_GAP: if (gap_ok) begin
          spi_cs_n  <= 1'b0;
          eng_start <= 1'b1;
          state     <= ret_state;
          case (ret_state)
            ST_RDSR: eng_tx <= OPC_RDSR;
            ST_WREN: eng_tx <= OPC_WREN;
            ST_WRDI: eng_tx <= OPC_WRDI;
            default: eng_tx <= is_erase ? OPC_ERASE : OPC_PROG;
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (spi_cs_n && !op_done && !op_err));
  a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
    op_done |=> !op_done);
  a_r2_err_excl_done: assert property (@(posedge clk) disable iff (rst)
    !(op_done && op_err));
  a_r10_cs_edge_sclk_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_cs_n) |-> !spi_sclk);
  a_r13_data_in_frame: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> (!spi_cs_n && !eng_active));
  a_r7_page_end_closes: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && eng_done && addr[PG_W-1:0] == '1) |=> spi_cs_n);
endmodule

// File: tb/nor_pe_seq_test.sv
`timescale 1ns/1ps
module nor_pe_seq_test;
  localparam int LEN_W = 16;
  localparam int GAP_W = 8;
  localparam int MEMSZ = 8192;
  localparam int BUSY_POLLS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_erase = 1'b0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0] wr_data;
  logic wr_valid = 1'b0;
  logic [GAP_W-1:0] gap_cycles = 8'd2;
  logic req_ready, wr_ready, op_done, op_err, spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  nor_pe_seq #(.LEN_W(LEN_W), .GAP_W(GAP_W), .SCLK_HALF(1)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .gap_cycles(gap_cycles), .op_done(op_done), .op_err(op_err),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // ---------------- data stream feeder ----------------
  int  didx = 0;
  int  cyc = 0;
  logic stall_en = 1'b0;
  assign wr_data = 8'(didx * 7 + 3);
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wr_ready && wr_valid) didx <= didx + 1;
    wr_valid <= stall_en ? (cyc % 3 != 0) : 1'b1;
  end

  // ---------------- chip select high-time monitor (R11) ----------------
  int hcnt = 0, gap_viol = 0;
  always @(posedge clk) begin
    if (rst) hcnt = 0;
    else if (spi_cs_n) hcnt = hcnt + 1;
    else begin
      if (hcnt > 0 && hcnt < int'(gap_cycles)) gap_viol = gap_viol + 1;
      hcnt = 0;
    end
  end

  // ---------------- behavioural flash ----------------
  logic [7:0] mem [0:MEMSZ-1];
  logic [7:0] ophist [0:1023];
  int n_ops = 0, n_pp = 0, n_se = 0, n_falls = 0;
  int viol_busy = 0, viol_wel = 0, viol_page = 0, edge_viol = 0;
  logic wel = 1'b0;
  int busy_cnt = 0;

  initial begin
    logic pcs, psck;
    logic [7:0] sin, op, sout, lo;
    logic [23:0] cad;
    int bitc, bytec, ndata;
    pcs = 1'b1; psck = 1'b0; sin = '0; op = '0; sout = '0; cad = '0;
    bitc = 0; bytec = 0; ndata = 0;
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'hFF;
    forever begin
      @(spi_sclk or spi_cs_n);
      if (spi_cs_n !== pcs) begin
        if (spi_sclk === 1'b1) edge_viol++;
        if (spi_cs_n === 1'b0) begin
          bitc = 0; bytec = 0; ndata = 0; n_falls++;
        end else if (spi_cs_n === 1'b1 && bytec > 0) begin
          if (op == 8'h06) wel = 1'b1;
          if (op == 8'h04) wel = 1'b0;
          if (op == 8'h02 && bytec >= 5 && wel) begin
            wel = 1'b0; busy_cnt = BUSY_POLLS; n_pp++;
          end
          if (op == 8'h20 && bytec == 4 && wel) begin
            for (int i = 0; i < 4096; i++) mem[{cad[12], 12'(i)}] = 8'hFF;
            wel = 1'b0; busy_cnt = BUSY_POLLS; n_se++;
          end
        end
        pcs = spi_cs_n;
      end
      if (spi_sclk !== psck) begin
        if (spi_sclk === 1'b1 && spi_cs_n === 1'b0) begin
          sin = {sin[6:0], spi_mosi};
          bitc++;
          if (bitc == 8) begin
            bitc = 0;
            if (bytec == 0) begin
              op = sin;
              if (n_ops < 1024) ophist[n_ops] = sin;
              n_ops++;
              if (busy_cnt != 0 && sin != 8'h05) viol_busy++;
              if ((sin == 8'h02 || sin == 8'h20) && !wel) viol_wel++;
              if (sin == 8'h05) sout = {6'b0, wel, busy_cnt != 0};
            end else if (op == 8'h05) begin
              if (busy_cnt > 0) busy_cnt--;
              sout = {6'b0, wel, busy_cnt != 0};
            end else if (op == 8'h02 || op == 8'h20) begin
              if (bytec <= 3) cad = {cad[15:0], sin};
              else if (op == 8'h02) begin
                lo = cad[7:0] + 8'(ndata);
                if (wel) mem[{cad[12:8], lo}] = mem[{cad[12:8], lo}] & sin;
                ndata++;
                if (ndata > 256) viol_page++;
              end
            end
            bytec++;
          end
        end else if (spi_sclk === 1'b0 && spi_cs_n === 1'b0 && op == 8'h05 && bytec >= 1) begin
          spi_miso = sout[7];
          sout = {sout[6:0], 1'b0};
        end
        psck = spi_sclk;
      end
    end
  end

  // ---------------- checking helpers ----------------
  logic [7:0] exp_mem [0:MEMSZ-1];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic issue(input bit erase, input int a, input int len,
                       output bit got_done, output bit got_err, output bit ready_dropped);
    int w;
    @(negedge clk);
    w = 0;
    while (!req_ready && w < 1000) begin @(negedge clk); w++; end
    req_erase = erase; req_addr = 24'(a); req_len = LEN_W'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ready_dropped = !req_ready;
    got_done = op_done; got_err = op_err;
    w = 0;
    while (!got_done && !got_err && w < 60000) begin
      @(negedge clk); got_done = op_done; got_err = op_err; w++;
    end
  endtask

  task automatic run_prog(input int a, input int len, input int gap, input bit stall);
    bit d, e, rd;
    int pp0, n0, base, pages, last_nr;
    gap_cycles = GAP_W'(gap);
    stall_en = stall;
    pp0 = n_pp; n0 = n_ops;
    @(negedge clk);
    base = didx;
    for (int k = 0; k < len; k++) exp_mem[(a + k) % MEMSZ] = 8'((base + k) * 7 + 3);
    pages = ((a + len - 1) / 256) - (a / 256) + 1;
    issue(1'b0, a, len, d, e, rd);
    check(d && !e, "R12 program completes with op_done", d, 1);
    check(rd, "R12 req_ready low after accept", rd, 1);
    @(negedge clk);
    check(!op_done, "R12 op_done single cycle", op_done, 0);
    check(n_pp - pp0 == pages, "R7 program frame count", n_pp - pp0, pages);
    check(didx - base == len, "R13 bytes consumed", didx - base, len);
    check(ophist[n0] == 8'h06, "R5 first frame is write enable", ophist[n0], 8'h06);
    last_nr = 0;
    for (int i = n0; i < n_ops && i < 1024; i++) if (ophist[i] != 8'h05) last_nr = ophist[i];
    check(last_nr == 8'h04, "R8 last frame is write disable", last_nr, 8'h04);
    check(!wel && busy_cnt == 0, "R8 latch clear and idle at end", wel, 0);
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < MEMSZ; i++) if (mem[i] !== exp_mem[i]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    bit d, e, rd;
    int f0, se0;
    for (int i = 0; i < MEMSZ; i++) exp_mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    check(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1 bus idle in reset", spi_cs_n, 1);
    check(op_done === 1'b0 && op_err === 1'b0, "R1 no pulses in reset", op_done, 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check(req_ready === 1'b1, "R1 ready after guard time", req_ready, 1);

    // R4 R5 R6 R7 R13: sweep of starts, lengths, guard times and stalls
    run_prog(32'h0F0, 40, 0, 1'b0);   // crosses one boundary
    run_prog(32'h200, 256, 1, 1'b0);  // exact page
    run_prog(32'h3FF, 2, 2, 1'b1);    // last byte of a page then next
    run_prog(32'h500, 1, 3, 1'b0);    // single byte
    run_prog(32'h6F0, 300, 3, 1'b1);  // three pages
    run_prog(32'h1000, 20, 1, 1'b0);
    cmp_mem("R4 programmed contents");
    check(viol_busy == 0, "R6 frame sent while busy", viol_busy, 0);
    check(viol_wel == 0, "R5 frame sent without write enable", viol_wel, 0);
    check(viol_page == 0, "R7 page overrun in one frame", viol_page, 0);

    // R9: aligned erase
    se0 = n_se;
    gap_cycles = 8'd2;
    issue(1'b1, 32'h1000, 0, d, e, rd);
    check(d && !e, "R9 erase completes", d, 1);
    check(n_se - se0 == 1, "R9 one erase frame", n_se - se0, 1);
    for (int i = 4096; i < 8192; i++) exp_mem[i] = 8'hFF;
    cmp_mem("R9 sector cleared, rest kept");

    // R2: misaligned erase refused
    f0 = n_falls;
    issue(1'b1, 32'h1800, 0, d, e, rd);
    repeat (20) @(negedge clk);
    check(e && !d, "R2 misaligned erase gives op_err", e, 1);
    check(n_falls == f0, "R2 no frame opened", n_falls - f0, 0);

    // R3: zero length program refused
    f0 = n_falls;
    issue(1'b0, 32'h0100, 0, d, e, rd);
    repeat (20) @(negedge clk);
    check(e && !d, "R3 zero count gives op_err", e, 1);
    check(n_falls == f0, "R3 no frame opened", n_falls - f0, 0);
    cmp_mem("R3 memory unchanged after refusals");

    check(edge_viol == 0, "R10 chip select moved with SCLK high", edge_viol, 0);
    check(gap_viol == 0, "R11 chip select high time too short", gap_viol, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule